// File: doc/BRIEF.md
# 32-bit to 6-bit Streaming Gearbox

This block turns a stream of 32-bit words, offered on a valid/ready interface, into a continuous 6-bit parallel bus. A new 6-bit beat appears every second system clock cycle. A companion clock output toggles on every system cycle, so one full period of that clock covers exactly one beat. The bus only changes on the system edge that drives the companion clock low. The data is therefore steady around the companion clock's rising edge, where a receiver samples it.

Six does not divide thirty-two, so a word never splits into a whole number of beats. The block keeps an accumulator that holds the leftover bits of the current word. Each newly accepted word is appended directly above those leftover bits, so the bit stream crosses word boundaries with nothing lost or repeated. Beats take bits from the bottom of the accumulator, least-significant first. The pattern lines up again every 16 beats, which use exactly three words. A refill is requested early enough that a supplier with data ready never causes a gap.

If a beat falls due while fewer than six bits are held, the block skips that beat and holds the bus. It also raises a sticky underrun flag. This can only happen after the first beat since reset. Streaming picks up again, from the exact bit where it stopped, as soon as words return. The design is meant to sit between a memory-fed word FIFO and output pin drivers.

Top module: `word_beat_gearbox`

## Requirements
- R1: While words are offered without pause, a new 6-bit beat is presented every two system cycles with no skipped beat and no underrun.
- R2: `clk_o` is low after reset and inverts on every system clock edge outside reset.
- R3: `beat_o` changes only on a system edge at which `clk_o` falls (goes from 1 to 0); it never changes on an edge where `clk_o` rises.
- R4: Bits leave least-significant first: the first beat after reset carries bits 5:0 of the first accepted word, and each later word's bit 0 directly follows the previous word's bit 31, so the beats joined end to end reproduce the accepted words concatenated LSB first (16 beats per 3 words).
- R5: `in_ready` is high in a cycle exactly when the number of held bits, less six if a beat fires on the coming edge, is at most 5; a word accepted on that edge is appended above the remaining bits.
- R6: When a beat falls due (`clk_o` high) and fewer than 6 bits are held, no beat is emitted, `beat_o` holds its previous value and `underrun_o` rises and stays high until reset.
- R7: After an underrun, newly accepted words resume the stream from the first unsent bit, with the leftover bits from before the stall sent first.
- R8: Before the first beat after reset, a lack of data does not raise `underrun_o`.
- R9: Synchronous reset empties the accumulator, drives `beat_o` to 0, `clk_o` low and `underrun_o` low, leaving `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is offered |
| in_data | input | IN_W (32) | Input word |
| in_ready | output | 1 | Block accepts the offered word on this edge |
| beat_o | output | OUT_W (6) | Parallel output bus |
| clk_o | output | 1 | Companion clock, toggles every system cycle |
| underrun_o | output | 1 | Sticky flag: a beat fell due with too few bits held |

## Verification
Several properties are checked on every cycle: the companion clock toggles, the bus moves only on companion-clock falling edges, the underrun flag is sticky and the bus holds when the flag rises, and an accepted word always fits in the accumulator. Other behaviour can only be shown by the bench's scenarios, because it depends on the history of the data. That covers bit ordering across word boundaries, the carry of leftover bits across a stall, the exact cycles in which refills are requested, and the absence of an underrun before the first beat. The bench follows each of these with a bit-level model of the stream.

// File: rtl/wbg_pkg.sv
package wbg_pkg;
    localparam int unsigned DEF_IN_W  = 32;
    localparam int unsigned DEF_OUT_W = 6;

    // Smallest accumulator that can take a whole word on top of a
    // residue that is one bit short of a beat.
    function automatic int unsigned acc_bits(input int unsigned in_w, input int unsigned out_w);
        return in_w + out_w - 1;
    endfunction
endpackage

// File: rtl/wbg_pace.sv
module wbg_pace (
    input  logic clk,
    input  logic rst,
    output logic clk_o,
    output logic beat_due
);
    typedef struct packed {
        logic level;
    } pace_t;

    pace_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.level = ~s_q.level;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign clk_o    = s_q.level;
    // A beat is issued on the edge that drives the companion clock low.
    assign beat_due = s_q.level;
endmodule

// File: rtl/wbg_pack.sv
module wbg_pack #(
    parameter int unsigned IN_W  = 32,
    parameter int unsigned OUT_W = 6,
    parameter int unsigned ACC_W = 37,
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_due,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             in_ready,
    output logic [OUT_W-1:0] beat_data,
    output logic             beat_fire,
    output logic             starve,
    output logic [CNT_W-1:0] fill_cnt
);
    localparam logic [CNT_W-1:0] BEAT_BITS  = CNT_W'(OUT_W);
    localparam logic [CNT_W-1:0] WORD_BITS  = CNT_W'(IN_W);
    localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(ACC_W - IN_W);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic [OUT_W-1:0] bus;
    } pack_t;

    pack_t            s_d, s_q;
    logic [ACC_W-1:0] acc_left;
    logic [CNT_W-1:0] cnt_left;
    logic             take;

    always_comb begin
        s_d       = s_q;
        beat_fire = beat_due && (s_q.cnt >= BEAT_BITS);
        starve    = beat_due && !beat_fire;
        acc_left  = s_q.acc;
        cnt_left  = s_q.cnt;
        if (beat_fire) begin
            s_d.bus  = s_q.acc[OUT_W-1:0];
            acc_left = s_q.acc >> OUT_W;
            cnt_left = s_q.cnt - BEAT_BITS;
        end
        // Readiness depends on state only, never on in_valid.
        in_ready = (cnt_left <= ROOM_LIMIT);
        take     = in_valid && in_ready;
        s_d.acc  = acc_left;
        s_d.cnt  = cnt_left;
        if (take) begin
            s_d.acc = acc_left | (ACC_W'(in_data) << cnt_left);
            s_d.cnt = cnt_left + WORD_BITS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign beat_data = s_q.bus;
    assign fill_cnt  = s_q.cnt;
endmodule

// File: rtl/wbg_flag.sv
module wbg_flag (
    input  logic clk,
    input  logic rst,
    input  logic beat_fire,
    input  logic starve,
    output logic underrun_o
);
    typedef struct packed {
        logic armed;
        logic flag;
    } flag_t;

    flag_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (beat_fire)              s_d.armed = 1'b1;
        if (starve && s_q.armed)    s_d.flag  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign underrun_o = s_q.flag;
endmodule

// File: rtl/word_beat_gearbox.sv
module word_beat_gearbox #(
    parameter int unsigned IN_W  = wbg_pkg::DEF_IN_W,
    parameter int unsigned OUT_W = wbg_pkg::DEF_OUT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             in_ready,
    output logic [OUT_W-1:0] beat_o,
    output logic             clk_o,
    output logic             underrun_o
);
    localparam int unsigned ACC_W = wbg_pkg::acc_bits(IN_W, OUT_W);
    localparam int unsigned CNT_W = $clog2(ACC_W + 1);

    logic             beat_due;
    logic             beat_fire;
    logic             starve;
    logic [CNT_W-1:0] fill_cnt;

    wbg_pace u_pace (
        .clk      (clk),
        .rst      (rst),
        .clk_o    (clk_o),
        .beat_due (beat_due)
    );

    wbg_pack #(
        .IN_W  (IN_W),
        .OUT_W (OUT_W),
        .ACC_W (ACC_W),
        .CNT_W (CNT_W)
    ) u_pack (
        .clk       (clk),
        .rst       (rst),
        .beat_due  (beat_due),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .beat_data (beat_o),
        .beat_fire (beat_fire),
        .starve    (starve),
        .fill_cnt  (fill_cnt)
    );

    wbg_flag u_flag (
        .clk        (clk),
        .rst        (rst),
        .beat_fire  (beat_fire),
        .starve     (starve),
        .underrun_o (underrun_o)
    );
endmodule

// File: rtl/wbg_checker.sv
module wbg_checker #(
    parameter int unsigned IN_W  = 32,
    parameter int unsigned OUT_W = 6,
    parameter int unsigned ACC_W = 37,
    parameter int unsigned CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [OUT_W-1:0] beat_o,
    input logic             clk_o,
    input logic             underrun_o,
    input logic [CNT_W-1:0] fill_cnt
);
    AST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (clk_o != $past(clk_o)));                                      // R2

    AST_BUS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(beat_o) |-> $fell(clk_o));                                     // R3

    AST_ACCEPT_FITS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (fill_cnt >= CNT_W'(IN_W)));                 // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= CNT_W'(ACC_W));                                             // R5

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        underrun_o |=> underrun_o);                                             // R6

    AST_HOLD_ON_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun_o) |-> $stable(beat_o));                                 // R6
endmodule

bind word_beat_gearbox wbg_checker #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W),
    .ACC_W (ACC_W),
    .CNT_W (CNT_W)
) u_wbg_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .beat_o     (beat_o),
    .clk_o      (clk_o),
    .underrun_o (underrun_o),
    .fill_cnt   (fill_cnt)
);

// File: tb/word_beat_gearbox_bench.sv
`timescale 1ns/1ps
module word_beat_gearbox_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic [5:0]  beat_o;
    logic        clk_o;
    logic        underrun_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] seed = 32'h1357_9bdf;

    always #2.5 clk = ~clk;

    word_beat_gearbox u_word_beat_gearbox (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .beat_o     (beat_o),
        .clk_o      (clk_o),
        .underrun_o (underrun_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: offers one word, returns at posedge+1 after it was taken.
    task automatic send_word(input logic [31:0] w);
        bit took;
        in_valid = 1'b1;
        in_data  = w;
        do begin
            @(negedge clk);
            took = in_ready;
            @(posedge clk);
            #1;
        end while (!took);
    endtask

    function automatic logic [31:0] next_word();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // Scoreboard: bit queue filled on accepted words, drained per beat.
    bit         q[$];
    logic [5:0] exp_bus;
    bit         exp_under;
    bit         started;
    bit         was_rst;
    bit         prev_clk;

    always @(negedge clk) begin
        int n;
        int left;
        bit due;
        bit fire;
        if (rst) begin
            q.delete();
            exp_bus   = '0;
            exp_under = 1'b0;
            started   = 1'b0;
            was_rst   = 1'b1;
            prev_clk  = 1'b0;
        end else begin
            if (was_rst) chk(clk_o == 1'b0, "R2", 64'(clk_o), 64'd0);
            else         chk(clk_o == !prev_clk, "R2", 64'(clk_o), 64'(!prev_clk));
            chk(beat_o == exp_bus, "R3 R4 R7", 64'(beat_o), 64'(exp_bus));
            chk(underrun_o == exp_under, "R6 R8", 64'(underrun_o), 64'(exp_under));
            n    = q.size();
            due  = clk_o;
            fire = due && (n >= 6);
            left = fire ? n - 6 : n;
            chk(in_ready == (left <= 5), "R5", 64'(in_ready), 64'(left <= 5));
            if (fire) begin
                for (int k = 0; k < 6; k++) exp_bus[k] = q.pop_front();
                started = 1'b1;
            end else if (due && started) begin
                exp_under = 1'b1;
            end
            if (in_valid && in_ready)
                for (int k = 0; k < 32; k++) q.push_back(in_data[k]);
            prev_clk = clk_o;
            was_rst  = 1'b0;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(clk_o == 1'b0 && underrun_o == 1'b0 && beat_o == '0 && in_ready == 1'b1,
            "R9", {clk_o, underrun_o, beat_o, in_ready}, 64'b0000_0001);
        @(posedge clk); #1;
        rst = 1'b0;

        // R8: idle before the first beat raises nothing
        repeat (10) @(posedge clk);
        #1;
        chk(underrun_o == 1'b0, "R8", 64'(underrun_o), 64'd0);

        // R1 R4: seven words back to back (residue of 2 bits at the end)
        for (int i = 0; i < 7; i++) send_word(next_word());
        chk(underrun_o == 1'b0, "R1", 64'(underrun_o), 64'd0);
        in_valid = 1'b0;

        // R6: starve it
        repeat (40) @(posedge clk);
        #1;
        chk(underrun_o == 1'b1, "R6", 64'(underrun_o), 64'd1);

        // R7: resume, leftover bits go first; flag stays set
        send_word(32'hDEAD_BEEF);
        send_word(next_word());
        in_valid = 1'b0;
        chk(underrun_o == 1'b1, "R6 R7", 64'(underrun_o), 64'd1);
        repeat (40) @(posedge clk);
        #1;

        // R9: reset in the middle of operation
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(clk_o == 1'b0 && underrun_o == 1'b0 && beat_o == '0 && in_ready == 1'b1,
            "R9", {clk_o, underrun_o, beat_o, in_ready}, 64'b0000_0001);
        @(posedge clk); #1;
        rst = 1'b0;

        // R4: fixed patterns, two full 3-word periods
        send_word(32'hFFFF_FFFF);
        send_word(32'h0000_0000);
        send_word(32'hAAAA_AAAA);
        send_word(32'h5555_5555);
        send_word(32'h1234_5678);
        send_word(32'h9ABC_DEF0);
        chk(underrun_o == 1'b0, "R1 R4", 64'(underrun_o), 64'd0);
        in_valid = 1'b0;
        repeat (40) @(posedge clk);
        #1;
        finish_run();
    end
endmodule